// File: doc/BRIEF.md
# Interrupt status and acknowledge controller

This block collects event pulses from the command and receive engines of a network controller into an 8-bit status byte and drives one level-sensitive interrupt line towards the host. The host reads the status byte and a mask byte through a small byte port. It clears serviced status bits by writing ones to the acknowledge location. It rewrites the mask byte through the same port.

The line is re-evaluated in two situations. In any cycle that carries an event, the new status byte is filtered through the mask and the line follows the result. Mask bits 7..4 suppress their own status bits one by one. Status bits 3..0 always pass the filter. Mask bit 0 is a global disable. In a cycle that carries only an acknowledge, the line can only fall, and it falls exactly when the status byte becomes empty. All other cycles, mask writes included, leave the line where it was.

Top module: `irq_stat_ack_ctrl`

## Requirements
- R1: While rst_ni is low, the status byte, the mask byte and irq_o are all 0.
- R2: Each bit set in evt_i is ORed into the status byte at the next clock edge. The bit positions are: bit 7 command done, bit 6 frame received, bit 5 command engine not active, bit 4 receive engine not ready, bit 3 management-interface done, bit 2 software request, bit 0 pause frame.
- R3: A high sw_req_i sets status bit 2 (value 0x04) at the next edge.
- R4: A write with wr_en_i=1 and wr_sel_i=0 is an acknowledge. It clears every status bit written as 1 and keeps every bit written as 0.
- R5: If an event and an acknowledge touch the same status bit in one cycle, the bit stays set.
- R6: In a cycle with any event, irq_o becomes 1 exactly when the new status ANDed with (~mask | 0x0F) is nonzero and mask bit 0 is 0. Mask bits 7..4 gate status bits 7..4 one by one. Mask bits 3..1 gate nothing.
- R7: An event cycle with mask bit 0 set drives irq_o to 0, even when unmasked status bits are set.
- R8: In an acknowledge cycle without an event, irq_o goes to 0 if the new status byte is 0 and otherwise keeps its value.
- R9: In a cycle with no event and no acknowledge, irq_o keeps its value. This includes cycles with a mask write (wr_en_i=1, wr_sel_i=1), which loads the mask byte from wr_data_i.
- R10: rd_data_o shows the status byte when rd_sel_i=0 and the mask byte when rd_sel_i=1. It follows rd_sel_i without a clock edge.
- R11: irq_o is a register output. It changes only at the clock edge that ends the stimulus cycle, never within that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Event pulses, one bit per status bit |
| sw_req_i | input | 1 | Software interrupt request |
| wr_en_i | input | 1 | Host byte write strobe |
| wr_sel_i | input | 1 | Write target: 0 acknowledge, 1 mask |
| wr_data_i | input | 8 | Host write data |
| rd_sel_i | input | 1 | Read select: 0 status, 1 mask |
| rd_data_o | output | 8 | Selected byte |
| irq_o | output | 1 | Level interrupt line |

## Verification
The status byte, the mask byte and irq_o all take the effect of a stimulus cycle at the rising edge that ends that cycle. The read port then shows the new byte with no further delay. The bench applies inputs at the falling edge and samples irq_o once just after it, where it must still hold its old value. It advances its reference model at the rising edge and compares both read selections and irq_o a fraction of a cycle later. Directed steps cover collisions between events and acknowledges, partial acknowledges, masking and the global disable. A sparse random phase then mixes all of these.

// File: rtl/irq_sa_pkg.sv
package irq_sa_pkg;
  localparam int unsigned STAT_W_DEF  = 8;
  localparam int unsigned FIXED_LO    = 4;  // low bits never gated per bit
  localparam int unsigned GATE_BIT    = 0;  // mask bit acting as global disable
  localparam int unsigned SW_BIT      = 2;

  localparam int unsigned EV_CMD_DONE = 7;
  localparam int unsigned EV_FRAME_RX = 6;
  localparam int unsigned EV_CU_IDLE  = 5;
  localparam int unsigned EV_RU_NRDY  = 4;
  localparam int unsigned EV_MGMT     = 3;
  localparam int unsigned EV_PAUSE    = 0;

  typedef enum logic {
    SEL_STAT = 1'b0,
    SEL_MASK = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/irq_sa_status.sv
module irq_sa_status #(
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] stat_nxt_o
);
  logic [STAT_W-1:0] stat_q;

  // set after clear: an event beats an acknowledge of the same bit
  assign stat_nxt_o = (stat_q & ~clr_i) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_nxt_o;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_sa_mask.sv
module irq_sa_mask #(
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [STAT_W-1:0] data_i,
  output logic [STAT_W-1:0] mask_o
);
  logic [STAT_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= data_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_sa_line.sv
module irq_sa_line #(
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned FIXED_LO = 4,
  parameter int unsigned GATE_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] stat_nxt_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              evt_any_i,
  input  logic              ack_i,
  output logic              irq_o
);
  logic [STAT_W-1:0] pass;
  logic              cond;
  logic              irq_d;
  logic              irq_q;

  for (genvar i = 0; i < STAT_W; i++) begin : g_pass
    if (i < FIXED_LO) begin : g_fixed
      assign pass[i] = 1'b1;
    end else begin : g_gated
      assign pass[i] = ~mask_i[i];
    end
  end

  assign cond = (|(stat_nxt_i & pass)) & ~mask_i[GATE_BIT];

  always_comb begin
    irq_d = irq_q;
    if (evt_any_i)                 irq_d = cond;
    else if (ack_i && ~|stat_nxt_i) irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_stat_ack_ctrl.sv
module irq_stat_ack_ctrl
  import irq_sa_pkg::*;
#(
  parameter int unsigned STAT_W = STAT_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              sw_req_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [STAT_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_nxt;
  logic [STAT_W-1:0] mask_q;
  logic              ack_we;
  logic              mask_we;
  logic              evt_any;

  assign ack_we  = wr_en_i & (wr_sel_i == SEL_STAT);
  assign mask_we = wr_en_i & (wr_sel_i == SEL_MASK);

  always_comb begin
    set_vec         = evt_i;
    set_vec[SW_BIT] = evt_i[SW_BIT] | sw_req_i;
  end

  assign clr_vec = ack_we ? wr_data_i : '0;
  assign evt_any = |set_vec;

  irq_sa_status #(.STAT_W(STAT_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .clr_i      (clr_vec),
    .stat_o     (stat_q),
    .stat_nxt_o (stat_nxt)
  );

  irq_sa_mask #(.STAT_W(STAT_W)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we),
    .data_i (wr_data_i),
    .mask_o (mask_q)
  );

  irq_sa_line #(
    .STAT_W   (STAT_W),
    .FIXED_LO (FIXED_LO),
    .GATE_BIT (GATE_BIT)
  ) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stat_nxt_i (stat_nxt),
    .mask_i     (mask_q),
    .evt_any_i  (evt_any),
    .ack_i      (ack_we),
    .irq_o      (irq_o)
  );

  assign rd_data_o = (rd_sel_i == SEL_MASK) ? mask_q : stat_q;
endmodule

// File: rtl/irq_sa_chk.sv
module irq_sa_chk #(
  parameter int unsigned STAT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAT_W-1:0] evt_i,
  input logic              sw_req_i,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [STAT_W-1:0] wr_data_i,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] mask_q,
  input logic              irq_o
);
  logic quiet;
  assign quiet = (evt_i == '0) && !sw_req_i;

  a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  a_r3_sw_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_req_i |=> stat_q[2]);

  a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && wr_en_i && !wr_sel_i) |=> ((stat_q & $past(wr_data_i)) == '0));

  a_r7_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!quiet && mask_q[0]) |=> !irq_o);

  a_r8_ack_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && wr_en_i && !wr_sel_i) |=> (stat_q != '0 || !irq_o));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && !(wr_en_i && !wr_sel_i)) |=> $stable(irq_o));

  a_r9_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> (mask_q == $past(wr_data_i)));

  a_r8_irq_needs_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_q != '0));
endmodule

bind irq_stat_ack_ctrl irq_sa_chk #(.STAT_W(STAT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_i     (evt_i),
  .sw_req_i  (sw_req_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .stat_q    (stat_q),
  .mask_q    (mask_q),
  .irq_o     (irq_o)
);

// File: tb/irq_stat_ack_ctrl_bench.sv
module irq_stat_ack_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] evt_i = '0;
  logic       sw_req_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       wr_sel_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_sel_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_stat = '0;
  logic [7:0] m_mask = '0;
  logic       m_irq  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_stat_ack_ctrl u_irq_stat_ack_ctrl (
    .clk_i, .rst_ni, .evt_i, .sw_req_i, .wr_en_i, .wr_sel_i,
    .wr_data_i, .rd_sel_i, .rd_data_o, .irq_o
  );

  function automatic logic [7:0] f_stat(logic [7:0] s, logic [7:0] set, logic [7:0] clr);
    return (s & ~clr) | set;
  endfunction

  function automatic logic f_irq(logic cur, logic [7:0] sn, logic [7:0] mk,
                                 logic ev, logic ack);
    if (ev)  return ((sn & (~mk | 8'h0F)) != 8'h00) && !mk[0];
    if (ack && sn == 8'h00) return 1'b0;
    return cur;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, logic [7:0] ev, logic sw, logic we,
                      logic sel, logic [7:0] d);
    logic [7:0] set;
    logic [7:0] clr;
    logic [7:0] sn;
    @(negedge clk_i);
    evt_i = ev; sw_req_i = sw; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    #1 chk("R11 irq before edge", {7'd0, irq_o}, {7'd0, m_irq});
    @(posedge clk_i);
    set = ev | (sw ? 8'h04 : 8'h00);
    clr = (we && !sel) ? d : 8'h00;
    sn  = f_stat(m_stat, set, clr);
    m_irq  = f_irq(m_irq, sn, m_mask, set != 8'h00, we && !sel);
    m_stat = sn;
    if (we && sel) m_mask = d;
    #1 rd_sel_i = 1'b0;
    #1 chk({tag, " status"}, rd_data_o, m_stat);
    rd_sel_i = 1'b1;
    #1 chk({tag, " R10 mask"}, rd_data_o, m_mask);
    chk({tag, " irq"}, {7'd0, irq_o}, {7'd0, m_irq});
    evt_i = '0; sw_req_i = 1'b0; wr_en_i = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] rev;
    void'($urandom(32'h5EED_0042));
    #3;
    rd_sel_i = 1'b0;
    #1 chk("R1 reset status", rd_data_o, 8'h00);
    rd_sel_i = 1'b1;
    #1 chk("R1 reset mask", rd_data_o, 8'h00);
    chk("R1 reset irq", {7'd0, irq_o}, 8'h00);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    step("R2 cmd done", 8'h80, 0, 0, 0, 8'h00);          // stat 80 irq 1
    step("R4 R8 ack to empty", 8'h00, 0, 1, 0, 8'h80);   // stat 00 irq 0
    step("R3 sw request", 8'h00, 1, 0, 0, 8'h00);        // stat 04 irq 1
    step("R4 ack sw", 8'h00, 0, 1, 0, 8'h04);
    step("R9 mask write", 8'h00, 0, 1, 1, 8'hFE);        // irq stays 0
    step("R6 high masked", 8'h40, 0, 0, 0, 8'h00);       // stat 40 irq 0
    step("R6 low unmasked", 8'h08, 0, 0, 0, 8'h00);      // stat 48 irq 1
    step("R8 partial ack holds", 8'h00, 0, 1, 0, 8'h08); // stat 40 irq 1
    step("R9 mask write no drop", 8'h00, 0, 1, 1, 8'hF0);
    step("R8 ack rest", 8'h00, 0, 1, 0, 8'h40);          // irq 0
    step("R9 set gate", 8'h00, 0, 1, 1, 8'h01);
    step("R7 gated event", 8'h04, 0, 0, 0, 8'h00);       // stat 04 irq 0
    step("R9 clear gate no rise", 8'h00, 0, 1, 1, 8'h00);
    step("R2 pause bit", 8'h01, 0, 0, 0, 8'h00);         // stat 05 irq 1
    step("R5 event beats ack", 8'h01, 0, 1, 0, 8'h05);   // stat 01 irq 1
    step("R9 idle hold", 8'h00, 0, 0, 0, 8'h00);
    step("R4 keep zeros", 8'h00, 0, 1, 0, 8'h00);        // stat 01 kept
    step("R4 clear", 8'h00, 0, 1, 0, 8'hFF);
    step("R6 all high masked", 8'hF0, 0, 1, 1, 8'hF0);   // event uses old mask 00
    step("R6 masked high event", 8'h20, 0, 0, 0, 8'h00); // stat F0 masked, irq 0
    step("R7 gate with low bit", 8'h00, 0, 1, 1, 8'h0F);
    step("R7 gated low event", 8'h08, 0, 0, 0, 8'h00);   // irq 0

    for (int i = 0; i < 3000; i++) begin
      rev = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      case ($urandom % 6)
        0, 1:    step("R6 random", rev, ($urandom % 8) == 0, 1, 0, 8'($urandom));
        2:       step("R9 random", rev, 0, 1, 1, 8'($urandom) & (($urandom % 3 == 0) ? 8'hFF : 8'hFE));
        default: step("R2 random", rev, ($urandom % 8) == 0, 0, 0, 8'h00);
      endcase
    end
    summary();
  end
endmodule